// File: doc/BRIEF.md
# Parallel ADC Bus Control Sequencer

This block runs a byte-wide analog-to-digital converter that has a parallel bus, using only the system clock. A start request sets off a fixed sequence. First a write cycle places configuration bits on the shared data bus and starts a conversion. Next the block waits for the converter's status line to drop, or for a watchdog limit to expire. Last, a read cycle samples the 8-bit result. The two active-low selects always move together. The read/write select settles before either select falls. Every width and gap on the converter side is a number of clock cycles, rounded up from picosecond parameters and the clock period.

The converted byte is held in a register and announced with a single-cycle valid pulse. If the status line never drops, a single-cycle error pulse is raised instead and no read takes place. The host is meant to issue one start, wait for the pulse, and issue the next start. Starts that arrive while a sequence is in flight are dropped.

Top module: `adc_bus_sequencer`

## Requirements
- R1: While reset is low and after it is released, both selects are high, read/write select is high, bus drive is off, and valid, error and busy are low.
- R2: The two selects are always equal. The read/write select has held its value for at least one cycle before the selects fall.
- R3: A write strobe (selects low, read/write 0) lasts ceil(max(300 ns, 200 ns)/clock) cycles, which is 15 at 50 MHz. The bus carries cfgIn in bits [CFG_W-1:0], with zeros above, and is driven from one cycle before the strobe falls until the hold count (1 cycle at 50 MHz) has elapsed after it rises.
- R4: Selects and read/write are never all low for as many cycles as one conversion time (500 cycles at 50 MHz).
- R5: After a write, status is not acted on for ceil(700 ns/clock) cycles. A read strobe falls at least ceil(250 ns/clock) cycles after status is low, and at least the sum of both counts after the write strobe rose.
- R6: A read strobe (selects low, read/write 1) lasts ceil(250 ns/clock) cycles, which is 13. The bus is not driven during it. The result is sampled in its last low cycle.
- R7: The sampled byte appears on resData together with a one-cycle resValid pulse, and is held until the next successful read.
- R8: Bus drive does not return sooner than ceil(150 ns/clock) cycles (8) after a read strobe rises.
- R9: startReq is ignored from acceptance until the post-read float wait ends, so each accepted start produces exactly one write strobe.
- R10: If status has not been seen low within the watchdog count of cycles after the write phase, errPulse goes high for one cycle. No read strobe follows and no valid pulse follows, and the block returns to idle.
- R11: cfgIn is captured when a start is accepted. Later changes to cfgIn do not alter the value on the bus during that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request one write/convert/read sequence |
| cfgIn | input | CFG_W | Configuration bits for the write cycle |
| busy | output | 1 | Sequence in progress |
| adcCsN | output | 1 | Active-low select to converter |
| adcCeN | output | 1 | Active-low enable to converter |
| adcRdWr | output | 1 | 1 = read, 0 = write/convert |
| adcStatus | input | 1 | High while the converter is converting |
| busIn | input | DATA_W | Data bus as seen from the converter |
| busOut | output | DATA_W | Value driven onto the data bus |
| busOe | output | 1 | Enable for the bus output driver |
| resData | output | DATA_W | Last converted byte |
| resValid | output | 1 | One-cycle pulse on a new result |
| errPulse | output | 1 | One-cycle pulse on a watchdog expiry |

## Verification
The bench keeps the default 20 ns clock and the default converter timings, so the expected strobe widths and gaps are 15, 1, 35, 13, 13 and 8 cycles. It shortens the watchdog to 4 µs, which is 200 cycles. Conversions of up to 120 cycles therefore finish normally, and a status line held high trips the watchdog within a few hundred cycles. A converter model in the bench only drives valid read data from the 13th low cycle of the read strobe onward, so sampling one cycle early is visible at resData.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_WAIT_BUSY,
    ST_RD_SETUP,
    ST_RD_ACCESS,
    ST_RD_RELEASE,
    ST_FLOAT
  } seqState_t;

  // strobes from control to datapath, all registered in the datapath
  typedef struct packed {
    logic loadCfg;
    logic driveBus;
    logic strobe;
    logic readSel;
    logic capture;
    logic validPulse;
    logic errPulse;
  } seqCtl_t;

  function automatic int unsigned maxU(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // round a time up to whole clocks, never below one cycle
  function automatic int unsigned psToCycles(int unsigned ps, int unsigned clkPs);
    int unsigned c;
    c = (ps + clkPs - 1) / clkPs;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int WR_CYC   = 15,
  parameter int HOLD_CYC = 1,
  parameter int DLY_CYC  = 35,
  parameter int TO_CYC   = 1000,
  parameter int SD_CYC   = 13,
  parameter int RD_CYC   = 13,
  parameter int FLT_CYC  = 8,
  parameter int CNT_W    = 10
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    statusSync,
  output seqCtl_t ctl,
  output logic    busy
);

  seqState_t state, stateNext;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limitV;
  logic lastCyc;
  logic goRead;
  logic tmo;

  always_comb begin
    case (state)
      ST_WR_PULSE:  limitV = CNT_W'(WR_CYC);
      ST_WR_HOLD:   limitV = CNT_W'(HOLD_CYC);
      ST_RD_SETUP:  limitV = CNT_W'(SD_CYC);
      ST_RD_ACCESS: limitV = CNT_W'(RD_CYC);
      ST_FLOAT:     limitV = CNT_W'(FLT_CYC);
      default:      limitV = CNT_W'(1);
    endcase
  end

  assign lastCyc = (cnt == limitV - CNT_W'(1));
  assign goRead  = (state == ST_WAIT_BUSY) && (cnt >= CNT_W'(DLY_CYC)) && !statusSync;
  assign tmo     = (state == ST_WAIT_BUSY) && !goRead && (cnt == CNT_W'(TO_CYC - 1));

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:       if (startReq) stateNext = ST_WR_SETUP;
      ST_WR_SETUP:   if (lastCyc) stateNext = ST_WR_PULSE;
      ST_WR_PULSE:   if (lastCyc) stateNext = ST_WR_HOLD;
      ST_WR_HOLD:    if (lastCyc) stateNext = ST_WAIT_BUSY;
      ST_WAIT_BUSY: begin
        if (goRead)   stateNext = ST_RD_SETUP;
        else if (tmo) stateNext = ST_IDLE;
      end
      ST_RD_SETUP:   if (lastCyc) stateNext = ST_RD_ACCESS;
      ST_RD_ACCESS:  if (lastCyc) stateNext = ST_RD_RELEASE;
      ST_RD_RELEASE: if (lastCyc) stateNext = ST_FLOAT;
      ST_FLOAT:      if (lastCyc) stateNext = ST_IDLE;
      default:       stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= (stateNext != state) ? '0 : cnt + CNT_W'(1);
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.loadCfg    = (state == ST_IDLE) && startReq;
    ctl.driveBus   = (state == ST_WR_SETUP) || (state == ST_WR_PULSE) || (state == ST_WR_HOLD);
    ctl.readSel    = !ctl.driveBus;
    ctl.strobe     = (state == ST_WR_PULSE) || (state == ST_RD_ACCESS);
    ctl.capture    = (state == ST_RD_ACCESS) && lastCyc;
    ctl.validPulse = (state == ST_RD_RELEASE);
    ctl.errPulse   = tmo;
  end

  assign busy = (state != ST_IDLE);

  // R9: a new write phase is only entered from idle
  assert_start_only_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> (state != ST_WR_SETUP));

  // R10: the wait never outlives the watchdog count
  assert_wait_bounded_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_BUSY) |-> (cnt < CNT_W'(TO_CYC)));

  // R10: a timeout goes straight back to idle, skipping the read
  assert_timeout_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.errPulse |=> (state == ST_IDLE));

endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CFG_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int FLT_CYC     = 8,
  parameter int CONV_CYC    = 500
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [CFG_W-1:0]  cfgIn,
  input  logic [DATA_W-1:0] busIn,
  input  logic              statusIn,
  output logic              statusSync,
  output logic              adcCsN,
  output logic              adcCeN,
  output logic              adcRdWr,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [DATA_W-1:0] resData,
  output logic              resValid,
  output logic              errPulse
);

  localparam int LOW_W = $clog2(CONV_CYC + 1) + 1;
  localparam int FLT_W = $clog2(FLT_CYC + 1) + 1;

  logic [CFG_W-1:0] cfgReg;
  logic             capD;

  // status synchronizer, depth chosen by parameter
  logic [SYNC_STAGES:0] syncChain;
  assign syncChain[0] = statusIn;
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncChain[g+1] <= 1'b0;
      else       syncChain[g+1] <= syncChain[g];
    end
  end
  assign statusSync = syncChain[SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg   <= '0;
      adcCsN   <= 1'b1;
      adcCeN   <= 1'b1;
      adcRdWr  <= 1'b1;
      busOe    <= 1'b0;
      capD     <= 1'b0;
      resData  <= '0;
      resValid <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      if (ctl.loadCfg) cfgReg <= cfgIn;
      adcCsN   <= !ctl.strobe;
      adcCeN   <= !ctl.strobe;
      adcRdWr  <= ctl.readSel;
      busOe    <= ctl.driveBus;
      capD     <= ctl.capture;
      if (capD) resData <= busIn;
      resValid <= ctl.validPulse;
      errPulse <= ctl.errPulse;
    end
  end

  assign busOut = {{(DATA_W-CFG_W){1'b0}}, cfgReg};

  // checker state: run of all-low controls, time since a read strobe ended
  logic [LOW_W-1:0] allLowCnt;
  logic [FLT_W-1:0] sinceRdRise;
  logic             readLowQ;
  logic             readLow;
  assign readLow = !adcCsN && !adcCeN && adcRdWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      allLowCnt   <= '0;
      sinceRdRise <= FLT_W'(FLT_CYC);
      readLowQ    <= 1'b0;
    end else begin
      readLowQ <= readLow;
      if (!adcCsN && !adcCeN && !adcRdWr) begin
        if (allLowCnt != {LOW_W{1'b1}}) allLowCnt <= allLowCnt + LOW_W'(1);
      end else begin
        allLowCnt <= '0;
      end
      if (readLowQ && !readLow)                sinceRdRise <= FLT_W'(1);
      else if (sinceRdRise < FLT_W'(FLT_CYC))  sinceRdRise <= sinceRdRise + FLT_W'(1);
    end
  end

  assert_rw_settled_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcCsN) |-> $stable(adcRdWr));

  assert_no_continuous_R4: assert property (@(posedge clk) disable iff (!rstN)
    allLowCnt < LOW_W'(CONV_CYC));

  assert_no_drive_in_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    readLow |-> !busOe);

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  assert_bus_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOe) |-> (sinceRdRise >= FLT_W'(FLT_CYC)));

  assert_err_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !resValid);

endmodule

// File: rtl/adc_bus_sequencer.sv
module adc_bus_sequencer
  import adc_seq_pkg::*;
#(
  parameter int DATA_W          = 8,
  parameter int CFG_W           = 2,
  parameter int SYNC_STAGES     = 2,
  parameter int CLK_PS          = 20000,
  parameter int T_WR_PULSE_PS   = 300000,
  parameter int T_WR_DSETUP_PS  = 200000,
  parameter int T_WR_HOLD_PS    = 10000,
  parameter int T_START_DLY_PS  = 700000,
  parameter int T_CONV_PS       = 10000000,
  parameter int T_TIMEOUT_PS    = 20000000,
  parameter int T_STAT_RD_PS    = 250000,
  parameter int T_RD_PULSE_PS   = 250000,
  parameter int T_RD_ACCESS_PS  = 250000,
  parameter int T_FLOAT_PS      = 150000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [CFG_W-1:0]  cfgIn,
  output logic              busy,
  output logic              adcCsN,
  output logic              adcCeN,
  output logic              adcRdWr,
  input  logic              adcStatus,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [DATA_W-1:0] resData,
  output logic              resValid,
  output logic              errPulse
);

  localparam int WR_CYC   = psToCycles(maxU(T_WR_PULSE_PS, T_WR_DSETUP_PS), CLK_PS);
  localparam int HOLD_CYC = psToCycles(T_WR_HOLD_PS, CLK_PS);
  localparam int DLY_CYC  = psToCycles(T_START_DLY_PS, CLK_PS);
  localparam int CONV_CYC = psToCycles(T_CONV_PS, CLK_PS);
  localparam int TO_CYC   = psToCycles(T_TIMEOUT_PS, CLK_PS);
  localparam int SD_CYC   = psToCycles(T_STAT_RD_PS, CLK_PS);
  localparam int RD_CYC   = psToCycles(maxU(T_RD_PULSE_PS, T_RD_ACCESS_PS), CLK_PS);
  localparam int FLT_CYC  = psToCycles(T_FLOAT_PS, CLK_PS);
  localparam int MAX_CYC  = maxU(maxU(TO_CYC, WR_CYC), maxU(maxU(SD_CYC, RD_CYC), FLT_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  seqCtl_t ctl;
  logic    statusSync;

  adc_seq_ctrl #(
    .WR_CYC(WR_CYC), .HOLD_CYC(HOLD_CYC), .DLY_CYC(DLY_CYC), .TO_CYC(TO_CYC),
    .SD_CYC(SD_CYC), .RD_CYC(RD_CYC), .FLT_CYC(FLT_CYC), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .statusSync(statusSync),
    .ctl(ctl), .busy(busy)
  );

  adc_seq_dpath #(
    .DATA_W(DATA_W), .CFG_W(CFG_W), .SYNC_STAGES(SYNC_STAGES),
    .FLT_CYC(FLT_CYC), .CONV_CYC(CONV_CYC)
  ) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgIn(cfgIn), .busIn(busIn),
    .statusIn(adcStatus), .statusSync(statusSync),
    .adcCsN(adcCsN), .adcCeN(adcCeN), .adcRdWr(adcRdWr),
    .busOut(busOut), .busOe(busOe), .resData(resData),
    .resValid(resValid), .errPulse(errPulse)
  );

endmodule

// File: tb/sim_adc_bus_sequencer.sv
`timescale 1ns/1ps
module sim_adc_bus_sequencer;

  // expected cycle counts at a 20 ns clock, from the requirements
  localparam int WR_CYC   = 15;
  localparam int DLY_CYC  = 35;
  localparam int SD_CYC   = 13;
  localparam int RD_CYC   = 13;
  localparam int FLT_CYC  = 8;
  localparam int CONV_CYC = 500;
  localparam int NVEC     = 5;
  // {cfg[1:0], value[7:0], conversion length in cycles[7:0]}
  localparam logic [17:0] VEC [NVEC] = '{
    {2'b01, 8'hA5, 8'd40},
    {2'b10, 8'h00, 8'd120},
    {2'b11, 8'hFF, 8'd10},
    {2'b00, 8'h3C, 8'd0},
    {2'b10, 8'h81, 8'd60}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [1:0] cfgIn = '0;
  logic busy, csN, ceN, rdWr, busOe, resValid, errPulse;
  logic status = 1'b0;
  logic [7:0] busIn, busOut, resData;

  always #10 clk = ~clk;

  adc_bus_sequencer #(.T_TIMEOUT_PS(4000000)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cfgIn(cfgIn), .busy(busy),
    .adcCsN(csN), .adcCeN(ceN), .adcRdWr(rdWr), .adcStatus(status),
    .busIn(busIn), .busOut(busOut), .busOe(busOe), .resData(resData),
    .resValid(resValid), .errPulse(errPulse)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // converter model and port monitor
  logic [7:0] adcVal = 8'h00;
  logic [7:0] expBus = 8'h00;
  int  convLenCur = 0;
  bit  stuck = 0;
  int  wrCnt = 0, rdCnt = 0, allLow = 0, maxAllLow = 0;
  int  wrStrobes = 0, rdStrobes = 0, validSeen = 0, errSeen = 0;
  int  sinceWrRise = 100000, sinceRdRise = 100000, sinceStatLow = 0;
  bit  statFell = 0;
  int  convPhase = 0, convTimer = 0;
  bit  prevSel = 0, prevValid = 0, prevErr = 0, prevOe = 0;
  logic prevRdWr = 1'b1;

  assign busIn = (!csN && !ceN && rdWr && rdCnt >= RD_CYC) ? adcVal : 8'hEE;

  always @(negedge clk) begin
    if (rstN) begin
      automatic bit sel = !csN && !ceN;
      if (sinceWrRise < 100000) sinceWrRise++;
      if (sinceRdRise < 100000) sinceRdRise++;
      if (sinceStatLow < 100000) sinceStatLow++;
      if (csN != ceN) check(0, "R2", "selects differ", csN, ceN);
      if (sel && !prevSel) begin
        check(rdWr == prevRdWr, "R2", "rdWr changed at select fall", rdWr, prevRdWr);
        if (rdWr) begin
          rdStrobes++;
          check(statFell && sinceStatLow >= SD_CYC, "R5", "status-low to read", sinceStatLow, SD_CYC);
          check(sinceWrRise >= DLY_CYC + SD_CYC, "R5", "write to read gap", sinceWrRise, DLY_CYC + SD_CYC);
        end
      end
      if (sel && !rdWr) begin
        wrCnt++;
        if (!(busOe && busOut == expBus)) check(0, "R11", "bus during write", busOut, expBus);
      end
      if (sel && rdWr) begin
        rdCnt++;
        if (busOe) check(0, "R6", "bus driven during read", 1, 0);
      end
      if (!sel && prevSel) begin
        if (!prevRdWr) begin
          check(wrCnt == WR_CYC, "R3", "write strobe width", wrCnt, WR_CYC);
          check(busOe && busOut == expBus, "R3", "data hold after strobe", busOut, expBus);
          wrStrobes++;
          sinceWrRise = 0;
          statFell = 0;
          if (stuck) begin
            status <= 1'b1; convPhase = 3;
          end else if (convLenCur == 0) begin
            statFell = 1; sinceStatLow = 0; convPhase = 0;
          end else begin
            convPhase = 1; convTimer = 0;
          end
        end else begin
          check(rdCnt == RD_CYC, "R6", "read strobe width", rdCnt, RD_CYC);
          sinceRdRise = 0;
        end
        wrCnt = 0;
        rdCnt = 0;
      end
      if (sel && !rdWr) allLow++; else allLow = 0;
      if (allLow > maxAllLow) maxAllLow = allLow;
      if (busOe && !prevOe) check(sinceRdRise >= FLT_CYC, "R8", "bus drive after read", sinceRdRise, FLT_CYC);
      case (convPhase)
        1: begin convTimer++; if (convTimer >= 5) begin status <= 1'b1; convPhase = 2; convTimer = 0; end end
        2: begin convTimer++; if (convTimer >= convLenCur) begin
             status <= 1'b0; statFell = 1; sinceStatLow = 0; convPhase = 0; end end
        3: if (!stuck) begin status <= 1'b0; convPhase = 0; end
        default: ;
      endcase
      if (resValid) begin
        validSeen++;
        check(resData == adcVal, "R7", "result byte", resData, adcVal);
        check(!prevValid, "R7", "valid pulse width", 2, 1);
      end
      if (errPulse) begin
        errSeen++;
        check(!prevErr, "R10", "error pulse width", 2, 1);
      end
      prevSel = sel; prevRdWr = rdWr; prevValid = resValid; prevErr = errPulse; prevOe = busOe;
    end
  end

  task automatic runTxn(logic [1:0] cfg, logic [7:0] val, int convLen, bit extraStarts);
    int w0, r0, v0, e0;
    w0 = wrStrobes; r0 = rdStrobes; v0 = validSeen; e0 = errSeen;
    adcVal = val; convLenCur = convLen; expBus = {6'b0, cfg};
    cfgIn = cfg; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0; cfgIn = ~cfg;
    if (extraStarts) begin
      repeat (40) @(negedge clk);
      startReq = 1'b1; @(negedge clk); startReq = 1'b0;
      if (!stuck) begin
        while (!resValid) @(negedge clk);
        startReq = 1'b1; @(negedge clk); startReq = 1'b0;
      end
    end
    while (busy) @(negedge clk);
    if (extraStarts) repeat (30) @(negedge clk);
    check(wrStrobes - w0 == 1, "R9", "write strobes per start", wrStrobes - w0, 1);
    if (stuck) begin
      check(errSeen - e0 == 1, "R10", "error pulses", errSeen - e0, 1);
      check(rdStrobes - r0 == 0, "R10", "read strobes after timeout", rdStrobes - r0, 0);
      check(validSeen - v0 == 0, "R10", "valid after timeout", validSeen - v0, 0);
    end else begin
      check(rdStrobes - r0 == 1, "R6", "read strobes", rdStrobes - r0, 1);
      check(validSeen - v0 == 1, "R7", "valid pulses", validSeen - v0, 1);
      check(resData == val, "R7", "held result", resData, val);
    end
    check(!busy, "R9", "idle after sequence", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(csN && ceN && rdWr && !busOe && !resValid && !errPulse && !busy,
          "R1", "outputs in reset", {csN, ceN, rdWr, busOe, resValid, errPulse, busy}, 7'b1110000);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(csN && ceN && rdWr && !busOe && !busy, "R1", "outputs after reset",
          {csN, ceN, rdWr, busOe, busy}, 5'b11100);

    // table walk, back to back
    for (int i = 0; i < NVEC; i++) begin
      runTxn(VEC[i][17:16], VEC[i][15:8], int'(VEC[i][7:0]), 1'b0);
    end

    // R4: longest all-low run equals the write strobe and is under a conversion
    check(maxAllLow == WR_CYC && maxAllLow < CONV_CYC, "R4", "longest all-low run", maxAllLow, WR_CYC);

    // R9: starts during wait and during float are dropped
    runTxn(2'b01, 8'h5A, 30, 1'b1);

    // R10: status stuck high, then recovery; result from before stays held (R7)
    stuck = 1;
    runTxn(2'b11, 8'h77, 0, 1'b1);
    check(resData == 8'h5A, "R7", "result kept over timeout", resData, 8'h5A);
    stuck = 0;
    repeat (3) @(negedge clk);
    runTxn(2'b10, 8'hC3, 20, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule